// File: doc/BRIEF.md
# Inter-Processor Doorbell Controller

This block lets eleven on-chip agents signal each other through doorbells. Every agent owns a small register bank on a shared memory-mapped request bus. Writing a remote agent's bit to the own trigger register raises a doorbell there: the receiver sees the sender's bit in its interrupt status register, and the sender sees the receiver's bit in its observation register. The receiver clears the status bit by writing a one to it. That acknowledgement also drops the sender's observation bit, so a sender can poll until its message has been taken.

Each agent has a mask, changed through separate enable and disable registers. Each agent also has a level interrupt that stays high while any unmasked status bit is set. Four power-management agents accept only secure traffic. A non-secure access to their banks, or one that names them in a write, is refused with an error response and changes nothing. The bus has a parameterised number of request ports. Because of that, a trigger and an acknowledgement can reach the same status bit in the same cycle. A side query port reports the pending state of a local/remote pair.

Top module: `db_doorbell_ctrl`

## Requirements
- R1: After reset, all status and observation bits read zero. Every mask reads all ones (word 0x0F0F0301), and all interrupt outputs are low.
- R2: A write of word W to bank A offset 0x00 sets, for every agent B whose bit is set in W, the bit of A in B's status (offset 0x10) and the bit of B in A's observation (offset 0x04).
- R3: Writing ones to a status register (offset 0x10) clears those bits. The matching observation bits in the senders' banks clear in the same cycle.
- R4: When a trigger and an acknowledgement reach the same status bit in one cycle, the bit ends set.
- R5: Writing ones to offset 0x18 clears those mask bits, and writing ones to offset 0x1C sets them. If both reach the same bit in one cycle, the bit ends masked. Offset 0x14 returns the mask, and writes to it change nothing.
- R6: Agent A's interrupt output is high exactly when (status AND NOT mask) of bank A is nonzero.
- R7: A non-secure access to the bank of agents 3 to 6 returns an error with read data zero and changes no state.
- R8: A non-secure write to offset 0x00, 0x10, 0x18 or 0x1C whose data sets the bit of any of agents 3 to 6 returns an error and changes no state.
- R9: An access whose bank index (address bits 11:8) is 11 or higher returns an error with read data zero.
- R10: Agent bits in every register word are fixed: agent 0 at bit 0, agents 1 and 2 at bits 8 and 9, agents 3 to 6 at bits 16 to 19, and agents 7 to 10 at bits 24 to 27. Write data on other bits is ignored, and those bits and all other offsets read zero.
- R11: Each request receives its response (valid, error, read data) exactly one cycle later on the same port. Read data reflects the state before that cycle's writes.
- R12: The query port returns bit 0 when the local agent's doorbell to the remote is still unacknowledged, and bit 1 when a doorbell from the remote to the local agent is pending. An index of 11 or higher returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | N_PORTS | Request present, one bit per port |
| bus_write | input | N_PORTS | 1 = write, 0 = read |
| bus_secure | input | N_PORTS | Request carries secure attribute |
| bus_addr | input | N_PORTS*ADDR_W | Bank index in bits 11:8, register offset in bits 7:0, per port |
| bus_wdata | input | N_PORTS*32 | Write data per port |
| bus_rvalid | output | N_PORTS | Response present, one cycle after request |
| bus_err | output | N_PORTS | Response is an error |
| bus_rdata | output | N_PORTS*32 | Read data per port |
| irq | output | 11 | Level interrupt per agent |
| sum_local | input | 4 | Query: local agent index |
| sum_remote | input | 4 | Query: remote agent index |
| sum_state | output | 2 | Query result: bit 0 send pending, bit 1 receive pending |

## Verification
The properties assume that reset is asserted at the start. They also assume every request bit is a defined value on each cycle, whatever the address or security attribute. The stimulus keeps to this by driving all request fields from the bench at the falling edge, every cycle. Out-of-range bank indices, non-secure accesses and unmapped offsets are drawn freely, because the properties cover them. Several ports may hit the same bank and the same bits in one cycle. The checks do not depend on any order between ports.

// File: rtl/db_pkg.sv
// Shared constants and agent/bit mapping helpers for the doorbell controller.
// Assumes eleven agents whose bit positions are fixed by the register layout.
package db_pkg;
    localparam int NAG = 11;
    localparam int DW  = 32;
    localparam int OFF_W = 8;

    localparam logic [OFF_W-1:0] OFF_TRIG = 8'h00;
    localparam logic [OFF_W-1:0] OFF_OBS  = 8'h04;
    localparam logic [OFF_W-1:0] OFF_ISR  = 8'h10;
    localparam logic [OFF_W-1:0] OFF_IMR  = 8'h14;
    localparam logic [OFF_W-1:0] OFF_IER  = 8'h18;
    localparam logic [OFF_W-1:0] OFF_IDR  = 8'h1C;

    localparam int SEC_FIRST = 3;
    localparam int SEC_LAST  = 6;

    // Bit position of an agent inside every register word.
    function automatic int agent_bit(input int a);
        if (a == 0)      return 0;
        else if (a <= 2) return 7 + a;
        else if (a <= 6) return 13 + a;
        else             return 17 + a;
    endfunction

    // Gather agent bits out of a bus word.
    function automatic logic [NAG-1:0] word_to_agents(input logic [DW-1:0] w);
        logic [NAG-1:0] v;
        for (int a = 0; a < NAG; a++) v[a] = w[agent_bit(a)];
        return v;
    endfunction

    // Scatter an agent vector into a bus word.
    function automatic logic [DW-1:0] agents_to_word(input logic [NAG-1:0] v);
        logic [DW-1:0] w;
        w = '0;
        for (int a = 0; a < NAG; a++) w[agent_bit(a)] = v[a];
        return w;
    endfunction

    // Agents that accept only secure traffic.
    function automatic logic [NAG-1:0] secure_agents();
        logic [NAG-1:0] v;
        for (int a = 0; a < NAG; a++) v[a] = (a >= SEC_FIRST) && (a <= SEC_LAST);
        return v;
    endfunction

    localparam logic [NAG-1:0] SECURE_SET = secure_agents();
endpackage

// File: rtl/db_port_if.sv
// One bus request port: decodes bank and offset, applies the secure filter,
// turns an accepted write into per-bit set/clear requests, and returns a
// registered response one cycle later.
// Assumes the state arrays are indexed [owner*NAG + source].
module db_port_if
    import db_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int NN    = NAG * NAG,
    localparam int BNK_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              write,
    input  logic              secure,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [NN-1:0]     status_flat,
    input  logic [NN-1:0]     mask_flat,
    output logic [NN-1:0]     set_flat,
    output logic [NN-1:0]     ack_flat,
    output logic [NN-1:0]     en_flat,
    output logic [NN-1:0]     dis_flat,
    output logic              rvalid,
    output logic              rerr,
    output logic [DW-1:0]     rdata
);
    logic [BNK_W-1:0] bank;
    logic [OFF_W-1:0] off;
    logic [NAG-1:0]   wv;
    logic             bank_ok, bank_sec, guarded_off, deny, accept;
    logic [NAG-1:0]   rd_vec;
    logic [DW-1:0]    rdata_d;

    assign bank = addr[ADDR_W-1:OFF_W];
    assign off  = addr[OFF_W-1:0];
    assign wv   = word_to_agents(wdata);

    // Range and security filter for the addressed bank and the write data.
    always_comb begin
        bank_ok  = int'(bank) < NAG;
        bank_sec = 1'b0;
        for (int a = 0; a < NAG; a++)
            if (a == int'(bank) && SECURE_SET[a]) bank_sec = 1'b1;
        guarded_off = (off == OFF_TRIG) || (off == OFF_ISR) ||
                      (off == OFF_IER)  || (off == OFF_IDR);
        deny   = !bank_ok || (!secure && bank_sec) ||
                 (!secure && write && guarded_off && (|(wv & SECURE_SET)));
        accept = valid && !deny;
    end

    // Per-bit update requests produced by an accepted write.
    always_comb begin
        set_flat = '0;
        ack_flat = '0;
        en_flat  = '0;
        dis_flat = '0;
        for (int o = 0; o < NAG; o++) begin
            for (int s = 0; s < NAG; s++) begin
                if (accept && write) begin
                    set_flat[o*NAG+s] = (off == OFF_TRIG) && (s == int'(bank)) && wv[o];
                    ack_flat[o*NAG+s] = (off == OFF_ISR)  && (o == int'(bank)) && wv[s];
                    en_flat[o*NAG+s]  = (off == OFF_IER)  && (o == int'(bank)) && wv[s];
                    dis_flat[o*NAG+s] = (off == OFF_IDR)  && (o == int'(bank)) && wv[s];
                end
            end
        end
    end

    // Read data selection from the pre-update state.
    always_comb begin
        rd_vec = '0;
        for (int o = 0; o < NAG; o++) begin
            for (int s = 0; s < NAG; s++) begin
                if (off == OFF_OBS && s == int'(bank)) rd_vec[o] = status_flat[o*NAG+s];
                if (off == OFF_ISR && o == int'(bank)) rd_vec[s] = status_flat[o*NAG+s];
                if (off == OFF_IMR && o == int'(bank)) rd_vec[s] = mask_flat[o*NAG+s];
            end
        end
        rdata_d = (accept && !write) ? agents_to_word(rd_vec) : '0;
    end

    // Response register: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rerr   <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= valid;
            rerr   <= valid && deny;
            rdata  <= rdata_d;
        end
    end
endmodule

// File: rtl/db_state.sv
// Doorbell status matrix and mask matrix with interrupt generation.
// Assumes merged per-bit requests from all ports; a set beats a clear on
// status, and a disable beats an enable on the mask.
module db_state
    import db_pkg::*;
#(
    localparam int NN = NAG * NAG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NN-1:0] set_all,
    input  logic [NN-1:0] ack_all,
    input  logic [NN-1:0] en_all,
    input  logic [NN-1:0] dis_all,
    output logic [NN-1:0] status_flat,
    output logic [NN-1:0] mask_flat,
    output logic [NAG-1:0] irq
);
    for (genvar o = 0; o < NAG; o++) begin : g_agent
        logic [NAG-1:0] stat_q, mask_q;

        // Status row of agent o: set wins over acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n) stat_q <= '0;
            else        stat_q <= (stat_q & ~ack_all[o*NAG +: NAG]) | set_all[o*NAG +: NAG];
        end

        // Mask row of agent o: disable wins over enable.
        always_ff @(posedge clk) begin
            if (!rst_n) mask_q <= '1;
            else        mask_q <= (mask_q & ~en_all[o*NAG +: NAG]) | dis_all[o*NAG +: NAG];
        end

        assign status_flat[o*NAG +: NAG] = stat_q;
        assign mask_flat[o*NAG +: NAG]   = mask_q;
        assign irq[o] = |(stat_q & ~mask_q);
    end
endmodule

// File: rtl/db_summary.sv
// Pending-state query for a local/remote agent pair.
// Assumes indices at or above the agent count mean "no such pair".
module db_summary
    import db_pkg::*;
#(
    localparam int NN = NAG * NAG
) (
    input  logic [NN-1:0] status_flat,
    input  logic [3:0]    loc,
    input  logic [3:0]    rem,
    output logic [1:0]    state
);
    // Look up both directions of the pair in the status matrix.
    always_comb begin
        state = 2'b00;
        for (int o = 0; o < NAG; o++) begin
            for (int s = 0; s < NAG; s++) begin
                if (o == int'(rem) && s == int'(loc)) state[0] = status_flat[o*NAG+s];
                if (o == int'(loc) && s == int'(rem)) state[1] = status_flat[o*NAG+s];
            end
        end
    end
endmodule

// File: rtl/db_doorbell_ctrl.sv
// Top of the doorbell controller: N_PORTS request ports share one status
// and mask matrix; per-port update requests are OR-merged.
// Assumes all ports are synchronous to clk.
module db_doorbell_ctrl
    import db_pkg::*;
#(
    parameter int N_PORTS = 2,
    parameter int ADDR_W  = 12
) (
    input  logic [0:0]                clk,
    input  logic                      rst_n,
    input  logic [N_PORTS-1:0]        bus_valid,
    input  logic [N_PORTS-1:0]        bus_write,
    input  logic [N_PORTS-1:0]        bus_secure,
    input  logic [N_PORTS*ADDR_W-1:0] bus_addr,
    input  logic [N_PORTS*DW-1:0]     bus_wdata,
    output logic [N_PORTS-1:0]        bus_rvalid,
    output logic [N_PORTS-1:0]        bus_err,
    output logic [N_PORTS*DW-1:0]     bus_rdata,
    output logic [NAG-1:0]            irq,
    input  logic [3:0]                sum_local,
    input  logic [3:0]                sum_remote,
    output logic [1:0]                sum_state
);
    localparam int NN = NAG * NAG;

    logic [NN-1:0] status_flat, mask_flat;
    logic [NN-1:0] set_p [N_PORTS];
    logic [NN-1:0] ack_p [N_PORTS];
    logic [NN-1:0] en_p  [N_PORTS];
    logic [NN-1:0] dis_p [N_PORTS];
    logic [NN-1:0] set_all, ack_all, en_all, dis_all;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        db_port_if #(.ADDR_W(ADDR_W)) u_port (
            .clk        (clk[0]),
            .rst_n      (rst_n),
            .valid      (bus_valid[p]),
            .write      (bus_write[p]),
            .secure     (bus_secure[p]),
            .addr       (bus_addr[p*ADDR_W +: ADDR_W]),
            .wdata      (bus_wdata[p*DW +: DW]),
            .status_flat(status_flat),
            .mask_flat  (mask_flat),
            .set_flat   (set_p[p]),
            .ack_flat   (ack_p[p]),
            .en_flat    (en_p[p]),
            .dis_flat   (dis_p[p]),
            .rvalid     (bus_rvalid[p]),
            .rerr       (bus_err[p]),
            .rdata      (bus_rdata[p*DW +: DW])
        );
    end

    // Merge update requests from every port.
    always_comb begin
        set_all = '0;
        ack_all = '0;
        en_all  = '0;
        dis_all = '0;
        for (int p = 0; p < N_PORTS; p++) begin
            set_all |= set_p[p];
            ack_all |= ack_p[p];
            en_all  |= en_p[p];
            dis_all |= dis_p[p];
        end
    end

    db_state u_state (
        .clk        (clk[0]),
        .rst_n      (rst_n),
        .set_all    (set_all),
        .ack_all    (ack_all),
        .en_all     (en_all),
        .dis_all    (dis_all),
        .status_flat(status_flat),
        .mask_flat  (mask_flat),
        .irq        (irq)
    );

    db_summary u_sum (
        .status_flat(status_flat),
        .loc        (sum_local),
        .rem        (sum_remote),
        .state      (sum_state)
    );
endmodule

// File: rtl/db_doorbell_sva.sv
// Property checker for the doorbell controller, bound to the top module.
// Assumes reset is asserted at start and request fields are always defined.
module db_doorbell_sva
    import db_pkg::*;
#(
    parameter int N_PORTS = 2,
    parameter int ADDR_W  = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [N_PORTS-1:0]        bus_valid,
    input logic [N_PORTS-1:0]        bus_secure,
    input logic [N_PORTS*ADDR_W-1:0] bus_addr,
    input logic [N_PORTS-1:0]        bus_rvalid,
    input logic [N_PORTS-1:0]        bus_err,
    input logic [N_PORTS*DW-1:0]     bus_rdata,
    input logic [NAG-1:0]            irq,
    input logic [NAG*NAG-1:0]        mask_flat
);
    localparam logic [ADDR_W-1:0] LIM_RANGE = ADDR_W'(NAG << OFF_W);
    localparam logic [ADDR_W-1:0] SEC_LO    = ADDR_W'(SEC_FIRST << OFF_W);
    localparam logic [ADDR_W-1:0] SEC_HI    = ADDR_W'((SEC_LAST + 1) << OFF_W);

    for (genvar p = 0; p < N_PORTS; p++) begin : g_p
        logic [ADDR_W-1:0] a;
        assign a = bus_addr[p*ADDR_W +: ADDR_W];

        a_r11_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
            bus_valid[p] |=> bus_rvalid[p]);
        a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_valid[p] |=> !bus_rvalid[p]);
        a_r9_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid[p] && a >= LIM_RANGE) |=> bus_err[p]);
        a_r7_secure_bank: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid[p] && !bus_secure[p] && a >= SEC_LO && a < SEC_HI) |=> bus_err[p]);
        a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rvalid[p] && bus_err[p]) |-> (bus_rdata[p*DW +: DW] == '0));
    end

    for (genvar o = 0; o < NAG; o++) begin : g_a
        a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (&mask_flat[o*NAG +: NAG]) |-> !irq[o]);
    end

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq == '0));
endmodule

bind db_doorbell_ctrl db_doorbell_sva #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W)) u_sva (
    .clk       (clk[0]),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_secure(bus_secure),
    .bus_addr  (bus_addr),
    .bus_rvalid(bus_rvalid),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .mask_flat (mask_flat)
);

// File: tb/db_doorbell_ctrl_tb.sv
// Self-checking bench: seeded random traffic on two ports plus directed
// corners, compared against a bench-side model of the requirements.
module db_doorbell_ctrl_tb;
    localparam int NP = 2;
    localparam int AW = 12;
    localparam int NA = 11;

    logic [0:0]       clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP-1:0]    bus_valid = '0, bus_write = '0, bus_secure = '0;
    logic [NP*AW-1:0] bus_addr = '0;
    logic [NP*32-1:0] bus_wdata = '0;
    logic [NP-1:0]    bus_rvalid, bus_err;
    logic [NP*32-1:0] bus_rdata;
    logic [NA-1:0]    irq;
    logic [3:0]       sum_local = '0, sum_remote = '0;
    logic [1:0]       sum_state;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [NA-1:0] m_stat [NA];
    logic [NA-1:0] m_mask [NA];

    db_doorbell_ctrl #(.N_PORTS(NP), .ADDR_W(AW)) u_dut (.*);

    always #5 clk = ~clk;

    function automatic int bpos(input int a);
        if (a == 0) return 0;
        if (a < 3)  return a + 7;
        if (a < 7)  return a + 13;
        return a + 17;
    endfunction

    function automatic logic [31:0] to_word(input logic [NA-1:0] v);
        logic [31:0] w = '0;
        for (int a = 0; a < NA; a++) w[bpos(a)] = v[a];
        return w;
    endfunction

    function automatic logic [NA-1:0] from_word(input logic [31:0] w);
        logic [NA-1:0] v;
        for (int a = 0; a < NA; a++) v[a] = w[bpos(a)];
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle on both ports, predict, and check responses and state.
    task automatic step(input logic [NP-1:0] v, input logic [NP-1:0] w, input logic [NP-1:0] s,
                        input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                        input logic [31:0] d0, input logic [31:0] d1);
        logic [AW-1:0] ad [NP];
        logic [31:0]   dd [NP];
        logic [31:0]   exp_rd [NP];
        logic          exp_err [NP];
        string         tag [NP];
        logic [NA-1:0] setm [NA], ackm [NA], enm [NA], dism [NA];
        ad[0] = a0; ad[1] = a1; dd[0] = d0; dd[1] = d1;
        for (int o = 0; o < NA; o++) begin setm[o] = '0; ackm[o] = '0; enm[o] = '0; dism[o] = '0; end
        for (int p = 0; p < NP; p++) begin
            int bk = int'(ad[p][11:8]);
            logic [7:0] of = ad[p][7:0];
            logic [NA-1:0] wv = from_word(dd[p]);
            logic guarded = (of == 8'h00) || (of == 8'h10) || (of == 8'h18) || (of == 8'h1C);
            logic sec_bits = |wv[6:3];
            logic deny;
            logic [NA-1:0] rv = '0;
            deny = (bk >= NA) || (!s[p] && bk >= 3 && bk <= 6) ||
                   (!s[p] && w[p] && guarded && sec_bits);
            if (bk >= NA) tag[p] = "R9";
            else if (!s[p] && bk >= 3 && bk <= 6) tag[p] = "R7";
            else if (deny) tag[p] = "R8";
            else if (of == 8'h04) tag[p] = "R2";
            else if (of == 8'h10) tag[p] = "R3";
            else if (of == 8'h14) tag[p] = "R5";
            else tag[p] = "R10";
            exp_err[p] = v[p] && deny;
            if (v[p] && !deny && !w[p]) begin
                if (of == 8'h04) for (int o = 0; o < NA; o++) rv[o] = m_stat[o][bk];
                if (of == 8'h10) rv = m_stat[bk];
                if (of == 8'h14) rv = m_mask[bk];
            end
            exp_rd[p] = to_word(rv);
            if (v[p] && !deny && w[p]) begin
                if (of == 8'h00) for (int o = 0; o < NA; o++) if (wv[o]) setm[o][bk] = 1'b1;
                if (of == 8'h10) ackm[bk] |= wv;
                if (of == 8'h18) enm[bk]  |= wv;
                if (of == 8'h1C) dism[bk] |= wv;
            end
        end
        bus_valid = v; bus_write = w; bus_secure = s;
        bus_addr = {a1, a0}; bus_wdata = {d1, d0};
        @(posedge clk);
        @(negedge clk);
        bus_valid = '0;
        for (int o = 0; o < NA; o++) begin
            m_stat[o] = (m_stat[o] & ~ackm[o]) | setm[o];
            m_mask[o] = (m_mask[o] & ~enm[o]) | dism[o];
        end
        for (int p = 0; p < NP; p++) begin
            chk("R11 rvalid", 32'(bus_rvalid[p]), 32'(v[p]));
            if (v[p]) begin
                chk({tag[p], " err"}, 32'(bus_err[p]), 32'(exp_err[p]));
                chk({tag[p], " rdata"}, bus_rdata[p*32 +: 32], exp_rd[p]);
            end
        end
        begin
            logic [NA-1:0] ei;
            for (int o = 0; o < NA; o++) ei[o] = |(m_stat[o] & ~m_mask[o]);
            chk("R6 irq", 32'(irq), 32'(ei));
        end
    endtask

    // Check the pair query port against the model.
    task automatic query(input int l, input int r);
        logic [1:0] e = 2'b00;
        sum_local = 4'(l); sum_remote = 4'(r);
        #1;
        if (l < NA && r < NA) begin
            e[0] = m_stat[r][l];
            e[1] = m_stat[l][r];
        end
        chk("R12 summary", 32'(sum_state), 32'(e));
    endtask

    function automatic logic [AW-1:0] mk(input int bank, input logic [7:0] off);
        return {4'(bank), off};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] offs [8];
        void'($urandom(32'd20240611));
        offs[0] = 8'h00; offs[1] = 8'h04; offs[2] = 8'h10; offs[3] = 8'h14;
        offs[4] = 8'h18; offs[5] = 8'h1C; offs[6] = 8'h08; offs[7] = 8'h20;
        for (int o = 0; o < NA; o++) begin m_stat[o] = '0; m_mask[o] = '1; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        chk("R1 irq", 32'(irq), 32'd0);
        step(2'b11, 2'b00, 2'b11, mk(0, 8'h14), mk(10, 8'h04), 0, 0);
        chk("R1 mask word", to_word('1), 32'h0F0F0301);
        // R2/R10: agent 1 rings agents 0 and 7; unmapped data bits ride along.
        step(2'b01, 2'b01, 2'b11, mk(1, 8'h00), 0, 32'h0100_0001 | 32'h8000_0010, 0);
        step(2'b11, 2'b00, 2'b11, mk(1, 8'h04), mk(7, 8'h10), 0, 0);
        query(1, 7); query(7, 1); query(12, 1);
        // R4: ack and retrigger of the same bit in one cycle.
        step(2'b11, 2'b11, 2'b11, mk(1, 8'h00), mk(0, 8'h10), 32'h1, 32'h100);
        step(2'b01, 2'b00, 2'b11, mk(0, 8'h10), 0, 0, 0);
        chk("R4 kept", bus_rdata[31:0], 32'h100);
        // R5: enable and disable collide; disable wins; write to mask reg ignored.
        step(2'b11, 2'b11, 2'b11, mk(0, 8'h18), mk(0, 8'h1C), 32'h301, 32'h100);
        step(2'b01, 2'b01, 2'b01, mk(0, 8'h14), 0, 32'hFFFF_FFFF, 0);
        step(2'b01, 2'b00, 2'b01, mk(0, 8'h14), 0, 0, 0);
        // R7/R8: non-secure bank access and non-secure ring of a secure agent.
        step(2'b11, 2'b11, 2'b00, mk(4, 8'h00), mk(2, 8'h00), 32'h1, 32'h0002_0000);
        step(2'b11, 2'b00, 2'b00, mk(5, 8'h10), mk(13, 8'h10), 0, 0);
        // Random traffic.
        for (int i = 0; i < 3000; i++) begin
            logic [NP-1:0] v, w, s;
            logic [AW-1:0] a [NP];
            logic [31:0] d [NP];
            for (int p = 0; p < NP; p++) begin
                v[p] = ($urandom % 4) != 0;
                w[p] = ($urandom % 2) != 0;
                s[p] = ($urandom % 8) != 0;
                a[p] = mk($urandom % 13, offs[$urandom % 8]);
                d[p] = (($urandom % 2) != 0) ? to_word(11'($urandom)) : $urandom;
                if (($urandom % 4) == 0) d[p] = to_word(11'(1 << ($urandom % NA)));
            end
            step(v, w, s, a[0], a[1], d[0], d[1]);
            query($urandom % 12, $urandom % 12);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule